// File: doc/BRIEF.md
# Fractional Cache Clock Ratio Generator

This block derives the clock for a second-level cache interface from the core clock. The ratio between the two is programmable. It covers 1.5 to 4.0 core cycles in half-cycle steps, and whole ratios of 5, 6, 7 and 8 above that. The block does not use both edges of the core clock. Instead it runs from a clock at twice the core rate, so one tick of its own clock equals one core half-cycle. A cache period of ratio R is therefore 2·R ticks long. The cache clock is a registered output that goes high for the first half of each period, rounded up, and low for the rest.

A one-tick strobe coincides with every rising edge of the cache clock. Downstream registers that drive cache address and control use it, so their outputs move only on cache cycle boundaries. The block latches a new ratio code only when the current period ends. An unsupported code, or the 1.5 ratio without dual-data mode, raises an error flag and parks the cache clock low. A legal code applied later restarts the clock at once.

Top module: `cache_clk_ratio`

## Requirements
- R1: The 4-bit `ratioSel` code sets the period in ticks: code 0→3, 1→4, 2→5, 3→6, 4→7, 5→8, 6→10, 7→12, 8→14, 9→16 (ratio 1.5, 2.0, 2.5, 3.0, 3.5, 4.0, 5, 6, 7, 8).
- R2: Within a period of N ticks, `cacheClk` is high for ceil(N/2) ticks and then low for floor(N/2) ticks.
- R3: Code 0 is legal only while `dualData` is 1. Code 0 with `dualData` 0 sets `cfgErr` to 1 and holds `cacheClk` low.
- R4: Codes 10 to 15 set `cfgErr` to 1 and hold `cacheClk` low.
- R5: While the block is in the error state, applying a legal configuration clears `cfgErr` and raises `cacheClk` on the next tick.
- R6: `edgeStrobe` is high for exactly one tick, and only on the tick in which `cacheClk` rises. Every rising edge of `cacheClk` carries it.
- R7: A change of `ratioSel` or `dualData` during a running period has no effect until that period ends. This includes changes to illegal values, and `cfgErr` stays unchanged until then.
- R8: While `rstN` is low, `cacheClk`, `edgeStrobe` and `cfgErr` are 0. With a legal code, the first period starts on the first tick after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkHalf | input | 1 | Tick clock at twice the core rate (one tick = one core half-cycle) |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 4 | Ratio select code |
| dualData | input | 1 | Dual-data mode enable; qualifies the 1.5 ratio |
| cacheClk | output | 1 | Generated cache interface clock |
| edgeStrobe | output | 1 | One-tick pulse on each cache clock rising edge |
| cfgErr | output | 1 | Active configuration is rejected |

## Verification
The hardest case to reach is a ratio change that lands inside a running period. The old length must still complete, including an unchanged error flag, before the new code is taken. The bench synchronises to a detected rising edge of the cache clock. On that same sample it changes the code, from the longest ratio to a short one or to an illegal one. It then counts the remaining high and low ticks of the old period before it expects the new behaviour. Recovery from the error state is reached the same way. The bench parks the block on a rejected code and then counts ticks from the moment a legal code is applied.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CODE_W     = 4;
  localparam int MAX_HALVES = 16;
  localparam int CNT_W      = $clog2(MAX_HALVES + 1);
  localparam int LAST_HALF_CODE  = 5;  // codes 0..5: half-cycle steps
  localparam int LAST_WHOLE_CODE = 9;  // codes 6..9: whole-cycle steps

  typedef struct packed {
    logic             load;    // period boundary: take the new configuration
    logic             reqOk;   // requested configuration is legal
    logic             active;  // a legal period is running
    logic [CNT_W-1:0] hiLen;   // high-phase length of running period
  } ccrStrobe_t;
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic              clkHalf,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioSel,
  input  logic              dualData,
  input  logic [CNT_W-1:0]  cnt,
  output ccrStrobe_t        stb
);
  logic [CNT_W-1:0] reqLen;
  logic             reqOk;
  logic [CNT_W-1:0] curLen;
  logic             curValid;
  logic             atEnd;

  // Decode: half steps give 3..8 ticks, whole steps give 10..16 ticks.
  always_comb begin
    reqLen = '0;
    reqOk  = 1'b0;
    if (int'(ratioSel) <= LAST_HALF_CODE) begin
      reqLen = CNT_W'(int'(ratioSel) + 3);
      reqOk  = (ratioSel != '0) || dualData;
    end else if (int'(ratioSel) <= LAST_WHOLE_CODE) begin
      reqLen = CNT_W'((int'(ratioSel) - 1) * 2);
      reqOk  = 1'b1;
    end
  end

  assign atEnd = !curValid || (cnt == curLen - CNT_W'(1));

  always_ff @(posedge clkHalf or negedge rstN) begin
    if (!rstN) begin
      curLen   <= '0;
      curValid <= 1'b0;
    end else if (atEnd) begin
      curLen   <= reqOk ? reqLen : '0;
      curValid <= reqOk;
    end
  end

  always_comb begin
    stb.load   = atEnd;
    stb.reqOk  = reqOk;
    stb.active = curValid;
    stb.hiLen  = (curLen + CNT_W'(1)) >> 1;
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clkHalf) disable iff (!rstN)
    curValid |-> (cnt < curLen)); // R1

  AST_HOLD_MIDPERIOD: assert property (@(posedge clkHalf) disable iff (!rstN)
    (curValid && !atEnd) |=> ($stable(curLen) && curValid)); // R7
endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
(
  input  logic             clkHalf,
  input  logic             rstN,
  input  ccrStrobe_t       stb,
  output logic [CNT_W-1:0] cnt,
  output logic             cacheClk,
  output logic             edgeStrobe,
  output logic             cfgErr
);
  logic [CNT_W-1:0] cntNext;

  assign cntNext = cnt + CNT_W'(1);

  always_ff @(posedge clkHalf or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      cacheClk   <= 1'b0;
      edgeStrobe <= 1'b0;
      cfgErr     <= 1'b0;
    end else if (stb.load) begin
      cnt        <= '0;
      cacheClk   <= stb.reqOk;
      edgeStrobe <= stb.reqOk;
      cfgErr     <= !stb.reqOk;
    end else begin
      cnt        <= cntNext;
      cacheClk   <= stb.active && (cntNext < stb.hiLen);
      edgeStrobe <= 1'b0;
    end
  end

  AST_STROBE_ON_RISE: assert property (@(posedge clkHalf) disable iff (!rstN)
    edgeStrobe |-> (cacheClk && !$past(cacheClk))); // R6

  AST_RISE_HAS_STROBE: assert property (@(posedge clkHalf) disable iff (!rstN)
    $rose(cacheClk) |-> edgeStrobe); // R6

  AST_ERR_CLK_LOW: assert property (@(posedge clkHalf) disable iff (!rstN)
    cfgErr |-> !cacheClk); // R4

  AST_ERR_HOLDS_MIDPERIOD: assert property (@(posedge clkHalf) disable iff (!rstN)
    !stb.load |=> $stable(cfgErr)); // R7
endmodule

// File: rtl/cache_clk_ratio.sv
module cache_clk_ratio
  import ccr_pkg::*;
(
  input  logic              clkHalf,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioSel,
  input  logic              dualData,
  output logic              cacheClk,
  output logic              edgeStrobe,
  output logic              cfgErr
);
  ccrStrobe_t       stb;
  logic [CNT_W-1:0] cnt;

  ccr_ctrl u_ctrl (
    .clkHalf (clkHalf),
    .rstN    (rstN),
    .ratioSel(ratioSel),
    .dualData(dualData),
    .cnt     (cnt),
    .stb     (stb)
  );

  ccr_datapath u_dp (
    .clkHalf   (clkHalf),
    .rstN      (rstN),
    .stb       (stb),
    .cnt       (cnt),
    .cacheClk  (cacheClk),
    .edgeStrobe(edgeStrobe),
    .cfgErr    (cfgErr)
  );
endmodule

// File: tb/cache_clk_ratio_bench.sv
`timescale 1ns/1ps
module cache_clk_ratio_bench;
  logic       clkHalf = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] ratioSel = 4'd1;
  logic       dualData = 1'b1;
  logic       cacheClk, edgeStrobe, cfgErr;
  int         tests = 0;
  int         fails = 0;
  logic       finished = 1'b0;

  always #2.5 clkHalf = ~clkHalf;  // 200 MHz

  cache_clk_ratio u_cache_clk_ratio (
    .clkHalf(clkHalf), .rstN(rstN), .ratioSel(ratioSel), .dualData(dualData),
    .cacheClk(cacheClk), .edgeStrobe(edgeStrobe), .cfgErr(cfgErr)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Period length in ticks, from the code table in the requirements.
  function automatic int halves(input int code);
    case (code)
      0: return 3;  1: return 4;  2: return 5;  3: return 6;  4: return 7;
      5: return 8;  6: return 10; 7: return 12; 8: return 14; default: return 16;
    endcase
  endfunction

  task automatic waitRise(input string tag);
    logic prev = cacheClk;
    logic found = 1'b0;
    for (int i = 0; i < 100 && !found; i++) begin
      @(negedge clkHalf);
      if (!prev && cacheClk) found = 1'b1;
      prev = cacheClk;
    end
    check(found, tag, found, 1);
  endtask

  // Called on the sample where cacheClk has just risen; ends on the next rise.
  task automatic countPhases(input int expHi, input int expLo, input string tag);
    int hi = 1;
    int lo = 0;
    int extra = 0;
    check(edgeStrobe == 1'b1, {tag, " R6 strobe at rise"}, edgeStrobe, 1);
    @(negedge clkHalf);
    while (cacheClk && hi < 40) begin
      hi++;
      if (edgeStrobe) extra++;
      @(negedge clkHalf);
    end
    while (!cacheClk && lo < 40) begin
      lo++;
      if (edgeStrobe) extra++;
      @(negedge clkHalf);
    end
    check(hi == expHi, {tag, " high ticks"}, hi, expHi);
    check(lo == expLo, {tag, " low ticks"}, lo, expLo);
    check(extra == 0, {tag, " R6 no stray strobe"}, extra, 0);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    ratioSel = 4'd1;
    dualData = 1'b1;
    repeat (3) @(negedge clkHalf);
    check(!cacheClk && !edgeStrobe && !cfgErr, "R8 outputs low in reset",
          {cacheClk, edgeStrobe, cfgErr}, 0);
    rstN = 1'b1;
    @(negedge clkHalf);
    check(cacheClk && edgeStrobe, "R8 first period starts", {cacheClk, edgeStrobe}, 3);
    countPhases(2, 2, "R8 first period");
  endtask

  task automatic t_ratios;
    for (int c = 0; c <= 9; c++) begin
      ratioSel = 4'(c);
      dualData = 1'b1;
      waitRise("R1 rise found");
      countPhases((halves(c) + 1) / 2, halves(c) / 2, $sformatf("R1 R2 code %0d", c));
    end
  endtask

  task automatic t_dual_gate;
    int highs = 0;
    ratioSel = 4'd0;
    dualData = 1'b0;
    repeat (20) @(negedge clkHalf);
    check(cfgErr == 1'b1, "R3 error without dual-data", cfgErr, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clkHalf);
      if (cacheClk) highs++;
    end
    check(highs == 0, "R3 clock held low", highs, 0);
    dualData = 1'b1;
    @(negedge clkHalf);
    check(cacheClk && !cfgErr && edgeStrobe, "R5 restart after dual-data on",
          {cacheClk, cfgErr, edgeStrobe}, 5);
    countPhases(2, 1, "R5 1.5 ratio");
  endtask

  task automatic t_illegal;
    int highs = 0;
    ratioSel = 4'd12;
    repeat (20) @(negedge clkHalf);
    check(cfgErr == 1'b1, "R4 error on code 12", cfgErr, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clkHalf);
      if (cacheClk) highs++;
    end
    check(highs == 0, "R4 clock held low", highs, 0);
    ratioSel = 4'd3;
    @(negedge clkHalf);
    check(cacheClk && !cfgErr, "R5 restart after legal code", {cacheClk, cfgErr}, 2);
    countPhases(3, 3, "R5 code 3");
  endtask

  task automatic t_change;
    int errEarly = 0;
    ratioSel = 4'd9;
    waitRise("R7 sync");
    ratioSel = 4'd1;
    countPhases(8, 8, "R7 old period kept");
    countPhases(2, 2, "R7 new period");
    ratioSel = 4'd9;
    waitRise("R7 sync 2");
    countPhases(8, 8, "R7 back to 8.0");
    ratioSel = 4'd15;
    for (int i = 0; i < 15; i++) begin
      @(negedge clkHalf);
      if (cfgErr) errEarly++;
    end
    check(errEarly == 0, "R7 error waits for boundary", errEarly, 0);
    @(negedge clkHalf);
    check(cfgErr == 1'b1, "R7 error at boundary", cfgErr, 1);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_dual_gate();
    t_illegal();
    t_change();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule